// File: doc/BRIEF.md
# Three-Common LCD Waveform Generator

This block produces the digital drive pattern for a multiplexed liquid-crystal panel with three common electrodes and forty-two segment electrodes. It holds no pixel storage: a 126-bit display word is presented on its input, and each segment electrode takes three consecutive bits of that word, one for each common. Every output is a 2-bit level select that external analog switches turn into one of four voltages: ground, the lower bias level, the upper bias level, or the supply.

A frame has three phases, one for each common, and the phases advance on a slow tick input. The polarity of every level flips on each new frame, so that no pixel sees a net DC voltage. At run time the caller can choose between a third-bias drive and a half-bias drive, blank the segments while the commons keep running, or put the block to sleep. The first four segment pins can be handed over to static port outputs, and the last two can be given up to a key scanner. Every control is a plain level input, and every output is registered.

Top module: `lcd_tri_com_drv`

## Requirements
- R1: Segment pin s (counted from 0) in phase p (0 to 2) is lit when display bit 3*s+p is 1. Bit 0 is the first bit of the display word.
- R2: Level codes are 00 ground, 01 lower bias, 10 upper bias and 11 supply. In phase p, common p is at 11 when the polarity is 0 and at 00 when the polarity is 1. The other commons sit at 01 when the polarity is 0 and at 10 when the polarity is 1.
- R3: In third bias (bias_half=0), a lit segment is at 00 when the polarity is 0 and at 11 when the polarity is 1. An unlit segment is at 10 when the polarity is 0 and at 01 when the polarity is 1.
- R4: In half bias (bias_half=1), every middle level on commons and segments is emitted as 01, and code 10 never appears. The extreme levels are the same as in third bias.
- R5: After reset the block is in phase 0 with polarity 0. Each group of TICKS_PER_PHASE tick pulses advances the phase 0→1→2→0. The polarity toggles on the wrap from phase 2 to phase 0. Fewer ticks than the group size leave the phase unchanged.
- R6: While seg_off=1, every segment pin shows its unlit level and the commons keep running. When seg_off returns to 0, the segments follow the display word again.
- R7: port_mode selects the port pins. Code 00 selects none, 01 selects pin 0, 10 selects pins 0 and 1, and 11 selects pins 0 to 3. A selected pin drives 00 on its segment lane, sets port_en for that lane, and drives port_val from display bit 0, 3, 6 or 9 for lanes 0 to 3. Lanes that are not selected read port_en=0 and port_val=0.
- R8: While sleep=1, all common and segment lanes are 00 and ticks are ignored, so the phase and polarity hold. Port outputs keep working during sleep.
- R9: ks_claim[0] forces segment pin 40 to 00, and ks_claim[1] forces segment pin 41 to 00.
- R10: While rst_n=0, all common and segment lanes are 00, and port_en and port_val are 0, which returns every shared pin to segment function.
- R11: Every output reflects the inputs present at the preceding rising clock edge, with a latency of one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Frame timing pulse, one cycle wide |
| disp_bits | input | 126 | Display word, three bits per segment |
| bias_half | input | 1 | 1 selects half bias, 0 selects third bias |
| seg_off | input | 1 | Blank all segments |
| sleep | input | 1 | Drive commons and segments to ground and freeze timing |
| port_mode | input | 2 | Number of leading segment pins used as ports |
| ks_claim | input | 2 | Last two segment pins given to the key scanner |
| com_lvl | output | 6 | Level code per common, common k at bits 2k+1:2k |
| seg_lvl | output | 84 | Level code per segment, pin s at bits 2s+1:2s |
| port_en | output | 4 | Port function active per lane |
| port_val | output | 4 | Static port value per lane |

## Verification
A change on a level input shows on the outputs one rising edge later. A tick first updates the phase register and only reaches the outputs on the following edge, so it takes two edges. The bench drives every input on a falling edge and usually samples two falling edges later, which covers both paths. One directed check samples after a single edge to pin down the one-edge latency. Expected phase and polarity come from a tick count kept in the bench, and this count is paused while sleep is asserted.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef enum logic [1:0] {
    LVL_GND = 2'b00,
    LVL_LO  = 2'b01,
    LVL_HI  = 2'b10,
    LVL_VDD = 2'b11
  } lvl_t;

  // Level for a common electrode; sel marks the phase owner.
  function automatic lvl_t com_level(input logic sel, input logic pol, input logic half);
    if (sel)  return pol ? LVL_GND : LVL_VDD;
    if (half) return LVL_LO;
    return pol ? LVL_HI : LVL_LO;
  endfunction

  // Level for a segment electrode; lit takes the extreme opposite the selected common.
  function automatic lvl_t seg_level(input logic lit, input logic pol, input logic half);
    if (lit)  return pol ? LVL_VDD : LVL_GND;
    if (half) return LVL_LO;
    return pol ? LVL_LO : LVL_HI;
  endfunction

  // Which of the four leading pins are ports for a given mode code.
  function automatic logic [3:0] port_mask(input logic [1:0] mode);
    case (mode)
      2'b01:   return 4'b0001;
      2'b10:   return 4'b0011;
      2'b11:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int NUM_PH          = 3,
  parameter int TICKS_PER_PHASE = 2,
  localparam int PHW = (NUM_PH > 1) ? $clog2(NUM_PH) : 1,
  localparam int TCW = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           hold,
  output logic [PHW-1:0] phase,
  output logic           polarity
);

  logic [TCW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      phase    <= '0;
      polarity <= 1'b0;
    end else if (tick && !hold) begin
      if (tcnt == TCW'(TICKS_PER_PHASE - 1)) begin
        tcnt <= '0;
        if (phase == PHW'(NUM_PH - 1)) begin
          phase    <= '0;
          polarity <= ~polarity;
        end else begin
          phase <= phase + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_COM = 3,
  localparam int PHW = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PHW-1:0]       phase,
  input  logic                 polarity,
  input  logic                 half,
  input  logic                 sleep,
  output logic [2*NUM_COM-1:0] com_lvl
);

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    always_ff @(posedge clk) begin
      if (!rst_n || sleep)
        com_lvl[2*k +: 2] <= LVL_GND;
      else
        com_lvl[2*k +: 2] <= com_level(phase == PHW'(k), polarity, half);
    end
  end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG = 42,
  parameter int NUM_COM = 3,
  localparam int PHW    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int DISP_W = NUM_SEG * NUM_COM
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DISP_W-1:0]    disp_bits,
  input  logic [NUM_SEG-1:0]   blank,
  input  logic [PHW-1:0]       phase,
  input  logic                 polarity,
  input  logic                 half,
  input  logic                 seg_off,
  input  logic                 sleep,
  output logic [2*NUM_SEG-1:0] seg_lvl
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] grp;
    logic               lit;
    assign grp = disp_bits[s*NUM_COM +: NUM_COM];
    assign lit = !seg_off && grp[phase];

    always_ff @(posedge clk) begin
      if (!rst_n || sleep || blank[s])
        seg_lvl[2*s +: 2] <= LVL_GND;
      else
        seg_lvl[2*s +: 2] <= seg_level(lit, polarity, half);
    end
  end

endmodule

// File: rtl/lcd_tri_com_drv.sv
module lcd_tri_com_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG         = 42,
  parameter int NUM_COM         = 3,
  parameter int TICKS_PER_PHASE = 2,
  parameter int NUM_PORT        = 4,
  parameter int NUM_KS          = 2,
  localparam int DISP_W = NUM_SEG * NUM_COM,
  localparam int PHW    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [DISP_W-1:0]    disp_bits,
  input  logic                 bias_half,
  input  logic                 seg_off,
  input  logic                 sleep,
  input  logic [1:0]           port_mode,
  input  logic [NUM_KS-1:0]    ks_claim,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_PORT-1:0]  port_en,
  output logic [NUM_PORT-1:0]  port_val
);

  logic [PHW-1:0]      phase;
  logic                polarity;
  logic [3:0]          pmask_all;
  logic [NUM_PORT-1:0] pmask;
  logic [NUM_PORT-1:0] pbits;
  logic [NUM_SEG-1:0]  blank;

  assign pmask_all = port_mask(port_mode);

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    assign pmask[p] = pmask_all[p];
    assign pbits[p] = disp_bits[p*NUM_COM];
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_blank
    if (s < NUM_PORT) begin : g_pp
      assign blank[s] = pmask[s];
    end else if (s >= NUM_SEG - NUM_KS) begin : g_ks
      assign blank[s] = ks_claim[s - (NUM_SEG - NUM_KS)];
    end else begin : g_plain
      assign blank[s] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_en  <= '0;
      port_val <= '0;
    end else begin
      port_en  <= pmask;
      port_val <= pmask & pbits;
    end
  end

  lcd_frame_seq #(
    .NUM_PH(NUM_COM),
    .TICKS_PER_PHASE(TICKS_PER_PHASE)
  ) seq_i (
    .clk(clk),
    .rst_n(rst_n),
    .tick(tick),
    .hold(sleep),
    .phase(phase),
    .polarity(polarity)
  );

  lcd_com_drv #(.NUM_COM(NUM_COM)) com_i (
    .clk(clk),
    .rst_n(rst_n),
    .phase(phase),
    .polarity(polarity),
    .half(bias_half),
    .sleep(sleep),
    .com_lvl(com_lvl)
  );

  lcd_seg_drv #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) seg_i (
    .clk(clk),
    .rst_n(rst_n),
    .disp_bits(disp_bits),
    .blank(blank),
    .phase(phase),
    .polarity(polarity),
    .half(bias_half),
    .seg_off(seg_off),
    .sleep(sleep),
    .seg_lvl(seg_lvl)
  );

endmodule

// File: rtl/lcd_tri_com_drv_chk.sv
module lcd_tri_com_drv_chk #(
  parameter int NUM_SEG  = 42,
  parameter int NUM_COM  = 3,
  parameter int NUM_PORT = 4,
  parameter int NUM_KS   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bias_half,
  input logic                 seg_off,
  input logic                 sleep,
  input logic [1:0]           port_mode,
  input logic [NUM_KS-1:0]    ks_claim,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl,
  input logic [NUM_PORT-1:0]  port_en
);

  int   ext_cnt;
  logic any_hi;
  logic inner_extreme;

  always_comb begin
    ext_cnt = 0;
    any_hi  = 1'b0;
    for (int k = 0; k < NUM_COM; k++) begin
      if (com_lvl[2*k +: 2] == 2'b00 || com_lvl[2*k +: 2] == 2'b11) ext_cnt++;
      if (com_lvl[2*k +: 2] == 2'b10) any_hi = 1'b1;
    end
    inner_extreme = 1'b0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (seg_lvl[2*s +: 2] == 2'b10) any_hi = 1'b1;
      if (s >= NUM_PORT && s < NUM_SEG - NUM_KS &&
          (seg_lvl[2*s +: 2] == 2'b00 || seg_lvl[2*s +: 2] == 2'b11))
        inner_extreme = 1'b1;
    end
  end

  // R8
  sleep_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (com_lvl == '0 && seg_lvl == '0));

  // R2
  one_extreme_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (ext_cnt == 1));

  // R4
  half_no_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_half && !sleep) |=> !any_hi);

  // R6
  off_middle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_off && !sleep) |=> !inner_extreme);

  // R7
  no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_mode == 2'b00) |=> (port_en == '0));

  // R7
  port_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en[0] |-> (seg_lvl[1:0] == 2'b00));

  // R9
  ks_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_claim[NUM_KS-1] |=> (seg_lvl[2*NUM_SEG-1 -: 2] == 2'b00));

endmodule

bind lcd_tri_com_drv lcd_tri_com_drv_chk #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_PORT(NUM_PORT), .NUM_KS(NUM_KS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bias_half(bias_half), .seg_off(seg_off),
  .sleep(sleep), .port_mode(port_mode), .ks_claim(ks_claim),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl), .port_en(port_en)
);

// File: tb/lcd_tri_com_drv_tb.sv
module lcd_tri_com_drv_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TPP = 2;
  localparam int NS = 42;
  localparam int NC = 3;
  localparam int DW = NS * NC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [DW-1:0] disp_bits = '0;
  logic          bias_half = 1'b0;
  logic          seg_off = 1'b0;
  logic          sleep = 1'b0;
  logic [1:0]    port_mode = 2'b00;
  logic [1:0]    ks_claim = 2'b00;
  logic [5:0]    com_lvl;
  logic [83:0]   seg_lvl;
  logic [3:0]    port_en;
  logic [3:0]    port_val;

  int n_chk = 0;
  int n_bad = 0;
  int m_tc = 0, m_ph = 0, m_pol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_tri_com_drv #(.TICKS_PER_PHASE(TPP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .disp_bits(disp_bits),
    .bias_half(bias_half), .seg_off(seg_off), .sleep(sleep),
    .port_mode(port_mode), .ks_claim(ks_claim), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .port_en(port_en), .port_val(port_val)
  );

  // {sleep, seg_off, half, port_mode[2], ks_claim[2], pattern[2], expected com[6]} in phase 0, polarity 0
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,2'b00,2'b00,2'd1,6'b010111},
    {1'b0,1'b0,1'b0,2'b00,2'b00,2'd2,6'b010111},
    {1'b0,1'b0,1'b0,2'b00,2'b00,2'd3,6'b010111},
    {1'b0,1'b0,1'b1,2'b00,2'b00,2'd3,6'b010111},
    {1'b0,1'b1,1'b0,2'b00,2'b00,2'd1,6'b010111},
    {1'b0,1'b0,1'b0,2'b01,2'b00,2'd1,6'b010111},
    {1'b0,1'b0,1'b0,2'b10,2'b00,2'd3,6'b010111},
    {1'b0,1'b0,1'b0,2'b11,2'b01,2'd1,6'b010111},
    {1'b0,1'b0,1'b0,2'b00,2'b11,2'd2,6'b010111},
    {1'b1,1'b0,1'b0,2'b11,2'b10,2'd1,6'b000000},
    {1'b0,1'b1,1'b1,2'b10,2'b01,2'd3,6'b010111}
  };

  function automatic logic [DW-1:0] make_pat(input logic [1:0] sel);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      case (sel)
        2'd0: r[i] = 1'b0;
        2'd1: r[i] = 1'b1;
        2'd2: r[i] = (i % 2) == 1;
        default: r[i] = (i % 7 == 0) || (i % 3 == 1);
      endcase
    end
    return r;
  endfunction

  function automatic logic [3:0] mode_mask(input logic [1:0] m);
    case (m)
      2'b01: return 4'b0001;
      2'b10: return 4'b0011;
      2'b11: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  // R2 / R4 common levels
  function automatic logic [5:0] exp_com(input int ph, input int pol, input logic half, input logic slp);
    logic [5:0] r;
    for (int k = 0; k < NC; k++) begin
      if (slp) r[2*k +: 2] = 2'b00;
      else if (k == ph) r[2*k +: 2] = pol ? 2'b00 : 2'b11;
      else if (half) r[2*k +: 2] = 2'b01;
      else r[2*k +: 2] = pol ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

  // R1 / R3 / R4 / R6 / R7 / R8 / R9 segment levels
  function automatic logic [83:0] exp_seg(input logic [DW-1:0] b, input int ph, input int pol,
      input logic half, input logic off, input logic slp, input logic [1:0] pm, input logic [1:0] ks);
    logic [83:0] r;
    logic [3:0] pmk;
    logic lit;
    pmk = mode_mask(pm);
    for (int s = 0; s < NS; s++) begin
      lit = !off && b[3*s + ph];
      if (slp || (s < 4 && pmk[s]) || (s == 40 && ks[0]) || (s == 41 && ks[1]))
        r[2*s +: 2] = 2'b00;
      else if (lit) r[2*s +: 2] = pol ? 2'b11 : 2'b00;
      else if (half) r[2*s +: 2] = 2'b01;
      else r[2*s +: 2] = pol ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    check({tag, " com"}, 128'(com_lvl), 128'(exp_com(m_ph, m_pol, bias_half, sleep)));
    check({tag, " seg"}, 128'(seg_lvl),
          128'(exp_seg(disp_bits, m_ph, m_pol, bias_half, seg_off, sleep, port_mode, ks_claim)));
    check({tag, " port_en"}, 128'(port_en), 128'(mode_mask(port_mode)));
    check({tag, " port_val"}, 128'(port_val),
          128'(mode_mask(port_mode) & {disp_bits[9], disp_bits[6], disp_bits[3], disp_bits[0]}));
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      if (!sleep) begin
        if (m_tc == TPP - 1) begin
          m_tc = 0;
          if (m_ph == NC - 1) begin m_ph = 0; m_pol = 1 - m_pol; end
          else m_ph++;
        end else m_tc++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R10: reset holds everything low even with active-looking inputs
    port_mode = 2'b11;
    disp_bits = make_pat(2'd1);
    repeat (3) @(negedge clk);
    check("R10 com", 128'(com_lvl), 128'(0));
    check("R10 seg", 128'(seg_lvl), 128'(0));
    check("R10 port_en", 128'(port_en), 128'(0));
    check("R10 port_val", 128'(port_val), 128'(0));
    rst_n = 1'b1;
    port_mode = 2'b00;

    // Table walk in phase 0, polarity 0 (R1 R2 R3 R4 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sleep     = VEC[v][14];
      seg_off   = VEC[v][13];
      bias_half = VEC[v][12];
      port_mode = VEC[v][11:10];
      ks_claim  = VEC[v][9:8];
      disp_bits = make_pat(VEC[v][7:6]);
      settle();
      check($sformatf("R2 vec%0d com", v), 128'(com_lvl), 128'(VEC[v][5:0]));
      check_all($sformatf("R1/R3/R7 vec%0d", v));
    end

    // R11: one-edge latency on a display change
    @(negedge clk);
    sleep = 1'b0; seg_off = 1'b0; bias_half = 1'b0; port_mode = 2'b00; ks_claim = 2'b00;
    disp_bits = make_pat(2'd2);
    settle();
    @(negedge clk) disp_bits = make_pat(2'd3);
    @(posedge clk); @(negedge clk);
    check("R11 seg", 128'(seg_lvl), 128'(exp_seg(disp_bits, m_ph, m_pol, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00)));

    // R5: a partial tick group leaves the phase alone, full groups walk two frames
    pulse_ticks(1);
    settle();
    check("R5 partial com", 128'(com_lvl), 128'(exp_com(0, 0, 1'b0, 1'b0)));
    pulse_ticks(TPP - 1);
    settle();
    check_all("R5 ph1");
    for (int i = 0; i < 5; i++) begin
      pulse_ticks(TPP);
      settle();
      check_all($sformatf("R5 step%0d", i));
    end

    // R4: half bias with polarity 1
    while (m_pol == 0) pulse_ticks(TPP);
    @(negedge clk) bias_half = 1'b1;
    settle();
    check_all("R4 pol1");
    @(negedge clk) bias_half = 1'b0;

    // R8: sleep freezes timing, ports stay alive
    pulse_ticks(TPP);
    settle();
    @(negedge clk) begin sleep = 1'b1; port_mode = 2'b11; end
    settle();
    pulse_ticks(3 * TPP + 1);
    settle();
    check_all("R8 asleep");
    @(negedge clk) sleep = 1'b0;
    settle();
    check_all("R8 woke");

    // R6: blank then restore
    @(negedge clk) begin seg_off = 1'b1; port_mode = 2'b00; end
    settle();
    check_all("R6 off");
    @(negedge clk) seg_off = 1'b0;
    settle();
    check_all("R6 restored");

    // R9: both key lanes claimed in polarity-1 frame
    @(negedge clk) ks_claim = 2'b11;
    settle();
    check("R9 pin41", 128'(seg_lvl[83:80]), 128'(0));
    check_all("R9 full");

    // R10: reset mid-run returns to phase 0, polarity 0
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 mid com", 128'(com_lvl), 128'(0));
    @(negedge clk) rst_n = 1'b1;
    m_tc = 0; m_ph = 0; m_pol = 0;
    settle();
    check_all("R10 after");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule